// File: doc/BRIEF.md
# Huff-Puff Frequency Lock Detector

This block watches a free-running oscillator and produces the one-bit error signal of a huff-puff frequency stabiliser. The oscillator clocks a small counter in its own clock domain. Only the counter's lowest bit, its parity, is carried into the system clock domain, through a two-stage synchroniser. At a fixed sample rate, one sample every `CLKS_PER_SAMPLE` system clocks, the settled parity is captured. The captured bit is exclusive-ORed with the parity captured `TAPS` samples earlier, and the result drives `corr_out`.

An analog integrator outside the block averages `corr_out` into a tuning voltage. The detector makes no attempt at hysteresis. A correction that turns out to be unneeded is simply reversed by a later sample, and the long integrator time constant smooths these reversals out. Stable operating points fall at intervals of twice the sample rate divided by the tap count. With the default 2000 system clocks per sample and 2000 taps, a 20 MHz clock gives 10 kHz sampling and lock points 10 Hz apart.

`sample_stb` pulses for one cycle each time a sample is taken. It lets an observer line the output up with a reference model.

Top module: `drift_lock_det`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `corr_out` and `sample_stb` are 0 after that edge. The same reset clears the delay history, the sample-rate divider and the oscillator-domain counter.
- R2: `sample_stb` is high for exactly one cycle. Consecutive pulses are exactly `CLKS_PER_SAMPLE` cycles apart. The first pulse after reset release comes `CLKS_PER_SAMPLE` cycles after the first rising edge at which `rst_n` is high.
- R3: Each captured sample is the parity (count modulo 2) of the number of rising edges on `osc_in` since reset. This holds for edges that occur at least three system clocks before the sampling edge.
- R4: Once at least `TAPS` samples have been taken since reset, `corr_out` after the sampling edge of sample n is sample n XOR sample n−`TAPS`.
- R5: For the first `TAPS` samples after reset, the delayed bit reads as 0, so `corr_out` equals the newly captured sample.
- R6: `corr_out` changes only on the edge that raises `sample_stb`. It holds its value in every other cycle.
- R7: An even number of `osc_in` rising edges within one sample period leaves the sample unchanged. An odd number, one or three, inverts it.
- R8: A reset asserted in mid-run discards all earlier history. The next `TAPS` outputs again equal the newly captured samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all sampling and output logic runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; also used by the oscillator-domain counter |
| osc_in | input | 1 | Oscillator under control; asynchronous to `clk` |
| corr_out | output | 1 | Correction bit for the external integrator |
| sample_stb | output | 1 | One-cycle pulse marking the cycle in which a new sample and its correction appear |

## Verification
On every sampling edge, two things happen on the same clock: the newest parity bit enters the head of the delay line, and the oldest bit leaves its tail to be compared. The result is correct only if the comparison uses the tail as it stood before that edge's shift. The bench provokes this collision with constant, alternating, random and even-count oscillator patterns. It also runs across the fill boundary, where the tail first stops reading the reset zeros, and across a mid-run reset. A scoreboard judges every strobe against a history kept in the bench: it expects sample n XOR sample n−`TAPS`, and it requires the output to stay still between strobes.

// File: rtl/hpl_pkg.sv
// Shared constants for the huff-puff lock detector.
// Assumes: defaults describe a 20 MHz clock sampled at 10 kHz.
package hpl_pkg;
    localparam int DEF_TAPS       = 2000;
    localparam int DEF_CLKS_PER_S = 2000;
    localparam int DEF_CNT_W      = 8;
    localparam int SYNC_STAGES    = 2;
endpackage

// File: rtl/hpl_osc_counter.sv
// Free-running counter clocked by the oscillator itself; exposes its LSB.
// Assumes: rst_n is held low for at least one oscillator edge to clear it.
module hpl_osc_counter #(
    parameter int CNT_W = hpl_pkg::DEF_CNT_W
) (
    input  logic osc_clk,
    input  logic rst_n,
    output logic parity
);
    logic [CNT_W-1:0] count;

    // Count every oscillator rising edge, no prescaling.
    always_ff @(posedge osc_clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + 1'b1;
    end

    assign parity = count[0];
endmodule

// File: rtl/hpl_sync.sv
// Multi-stage synchroniser bringing one asynchronous bit into clk.
// Assumes: the input changes slowly relative to clk.
module hpl_sync #(
    parameter int STAGES = hpl_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Shift the async bit through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/hpl_rate_div.sv
// Sample-rate divider: flags the last clock of each sample period.
// Assumes: CLKS_PER_SAMPLE >= 2.
module hpl_rate_div #(
    parameter int CLKS_PER_SAMPLE = hpl_pkg::DEF_CLKS_PER_S
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int              CW   = $clog2(CLKS_PER_SAMPLE);
    localparam logic [CW-1:0]   LAST = CW'(CLKS_PER_SAMPLE - 1);

    logic [CW-1:0] cnt;

    // Wrap the period counter at the last clock of the period.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/hpl_delay_line.sv
// Single-bit delay line advanced once per sample.
// Assumes: TAPS >= 2; tail is the bit entered TAPS shifts ago (0 after reset).
module hpl_delay_line #(
    parameter int TAPS = hpl_pkg::DEF_TAPS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic din,
    output logic tail
);
    logic [TAPS-1:0] stages;

    // Clear on reset, shift the new sample in on each enable.
    always_ff @(posedge clk) begin
        if (!rst_n)        stages <= '0;
        else if (shift_en) stages <= {stages[TAPS-2:0], din};
    end

    assign tail = stages[TAPS-1];
endmodule

// File: rtl/drift_lock_det.sv
// Huff-puff frequency lock detector: samples the oscillator count parity,
// XORs it with the parity TAPS samples earlier, and drives the result.
// Assumes: osc_in is asynchronous; output feeds a slow external integrator.
module drift_lock_det #(
    parameter int TAPS            = hpl_pkg::DEF_TAPS,
    parameter int CLKS_PER_SAMPLE = hpl_pkg::DEF_CLKS_PER_S,
    parameter int CNT_W           = hpl_pkg::DEF_CNT_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_in,
    output logic corr_out,
    output logic sample_stb
);
    logic osc_par;
    logic par_sync;
    logic tick;
    logic old_bit;

    hpl_osc_counter #(.CNT_W(CNT_W)) u_cnt (
        .osc_clk (osc_in),
        .rst_n   (rst_n),
        .parity  (osc_par)
    );

    hpl_sync #(.STAGES(hpl_pkg::SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (osc_par),
        .q_sync  (par_sync)
    );

    hpl_rate_div #(.CLKS_PER_SAMPLE(CLKS_PER_SAMPLE)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    hpl_delay_line #(.TAPS(TAPS)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (tick),
        .din      (par_sync),
        .tail     (old_bit)
    );

    // Compare new sample with pre-shift tail and flag the sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            corr_out   <= 1'b0;
            sample_stb <= 1'b0;
        end else begin
            sample_stb <= tick;
            if (tick) corr_out <= par_sync ^ old_bit;
        end
    end
endmodule

// File: rtl/drift_lock_det_chk.sv
// Checker for drift_lock_det: reset values, strobe spacing, output hold.
// Assumes: bound to every instance of drift_lock_det.
module drift_lock_det_chk #(
    parameter int CLKS_PER_SAMPLE = hpl_pkg::DEF_CLKS_PER_S
) (
    input logic clk,
    input logic rst_n,
    input logic corr_out,
    input logic sample_stb
);
    localparam int GW = $clog2(CLKS_PER_SAMPLE + 1) + 1;
    localparam logic [GW-1:0] PERIOD = GW'(CLKS_PER_SAMPLE);

    logic [GW-1:0] gap;

    // Count cycles since reset or since the last strobe, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)               gap <= '0;
        else if (sample_stb)      gap <= GW'(1);
        else if (gap <= PERIOD)   gap <= gap + 1'b1;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!corr_out && !sample_stb));

    assert_stb_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb);

    assert_stb_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> (gap == PERIOD));

    assert_no_missed_stb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        gap <= PERIOD);

    assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |-> $stable(corr_out));
endmodule

bind drift_lock_det drift_lock_det_chk #(.CLKS_PER_SAMPLE(CLKS_PER_SAMPLE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .corr_out   (corr_out),
    .sample_stb (sample_stb)
);

// File: tb/sim_drift_lock_det.sv
// Scoreboard bench: driver pushes expected corrections, monitor compares.
module sim_drift_lock_det;
    localparam int TAPS = 16;
    localparam int CPS  = 8;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic osc   = 1'b0;
    logic corr_out;
    logic sample_stb;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    bit    exp_q[$];
    string tag_q[$];
    bit    hist[$];
    bit    par = 1'b0;
    string fill_tag = "R5";
    logic [7:0] lfsr = 8'hA5;

    always #5 clk = ~clk;

    drift_lock_det #(.TAPS(TAPS), .CLKS_PER_SAMPLE(CPS), .CNT_W(4)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .osc_in     (osc),
        .corr_out   (corr_out),
        .sample_stb (sample_stb)
    );

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
        end
    endtask

    task automatic pulse_osc(input int n);
        for (int i = 0; i < n; i++) begin
            #1 osc = 1'b1;
            #1 osc = 1'b0;
        end
    endtask

    // Driver side: expected correction for the sample now being built.
    task automatic push_exp(input string tag);
        bit d;
        d = (hist.size() >= TAPS) ? hist[hist.size() - TAPS] : 1'b0;
        exp_q.push_back(par ^ d);
        tag_q.push_back(hist.size() < TAPS ? fill_tag : tag);
        hist.push_back(par);
    endtask

    task automatic do_reset();
        @(negedge clk);
        #2 rst_n = 1'b0;
        pulse_osc(2);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R1 reset corr_out", int'(corr_out), 0);
            check("R1 reset sample_stb", int'(sample_stb), 0);
        end
        exp_q.delete();
        tag_q.delete();
        hist.delete();
        par = 1'b0;
        push_exp("R1");
        #2 rst_n = 1'b1;
    endtask

    // mode 0 constant, 1 alternate, 2 two edges, 3 random 0..3 edges
    task automatic run_phase(input int mode, input int n, input string tag);
        int k;
        for (int i = 0; i < n; i++) begin
            do @(negedge clk); while (!sample_stb);
            case (mode)
                0:       k = 0;
                1:       k = 1;
                2:       k = 2;
                default: begin
                    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                    k = int'(lfsr[1:0]);
                end
            endcase
            par = par ^ k[0];
            push_exp(tag);
            pulse_osc(k);
        end
    endtask

    // Monitor: pops an expectation at each strobe, checks hold and spacing.
    int  gap  = 0;
    bit  held = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            gap  = 0;
            held = 1'b0;
        end else begin
            gap++;
            if (sample_stb) begin
                check("R2 strobe spacing", gap, CPS);
                gap = 0;
                if (exp_q.size() == 0) begin
                    check("R4 scoreboard underflow", 1, 0);
                end else begin
                    check(tag_q.pop_front(), int'(corr_out), int'(exp_q.pop_front()));
                end
                held = corr_out;
            end else begin
                check("R6 hold between strobes", int'(corr_out), int'(held));
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog: actual %0d cycles expected below 50000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        run_phase(0, 40, "R4");   // constant parity
        run_phase(1, 40, "R3");   // one edge per period, alternating
        run_phase(3, 60, "R3");   // random 0..3 edges
        run_phase(2, 40, "R7");   // even edge count keeps the sample
        run_phase(3, 20, "R7");
        fill_tag = "R8";
        do_reset();               // mid-run reset drops history
        run_phase(3, 40, "R4");
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule